// File: doc/BRIEF.md
# Multi-width host bus slave with register bank and data queues

This block is a synchronous slave on a plain microprocessor bus. A host reaches a bank of 32 word-aligned 16-bit registers and a pair of data queues through it: words the host writes to the queue window leave on an outbound stream, and words that arrive on an inbound stream are read by the host from the same window. A static two-bit width setting picks an 8-, 16- or 32-bit host bus. The block steers the byte lanes for that width and decodes each access as either a register access or a queue access. It also paces burst transfers, so that a wait input stretches each burst beat to two clocks.

Every access is qualified by an active-low chip select. An active-low write strobe separates writes from reads. A five-bit word address picks the register, and a queue-select line overrides that address. Each completed beat is reported on `beat_ack`. Read data is registered and appears with `rd_valid` one clock after the acknowledged beat, and `rdata` holds its value between reads.

Both streams use valid/ready. A word moves on a clock edge where valid and ready are both high. `tx_valid` stays high and `tx_data` stays stable until the consumer takes the word. `rx_ready` is low while the inbound queue is full, and the producer must hold `rx_valid` and `rx_data` until it sees ready.

Top module: `hbus_slave`

## Requirements
- R1: Out of reset, `rd_valid`, `ovf_flag`, `unf_flag` and `tx_valid` are 0, `rdata` is 0, `rx_ready` is 1, and every register reads 0.
- R2: A register write with width code 2'b10 (32-bit) changes only the register bytes whose active-low lane enable is 0. Lane 0 writes register bits 7:0 and lane 1 writes bits 15:8. Lanes 3 and 2 never change a register.
- R3: A register read in the 16- or 32-bit widths returns the register in `rdata[15:0]` and zero in `rdata[31:16]`, with `rd_valid` high exactly one clock after the acknowledged beat.
- R4: With `fifo_sel` = 0, `word_addr` (host address bits 6:2, bit 6 most significant) picks the register. With `fifo_sel` = 1 the access goes to the queues whatever `word_addr` holds.
- R5: Width code 2'b01 (16-bit) treats lane enables 3 and 2 as inactive. A queue write stores zero in bits 31:16, and a queue read returns zero in bits 31:16.
- R6: Width code 2'b00 (8-bit) uses `lane_en_n[0]` as address bit 0. When it is 0 the access reaches register bits 7:0, and when it is 1 it reaches bits 15:8. Data always travels on `wdata[7:0]`/`rdata[7:0]`, and `rdata[31:8]` is zero. A queue write stores only `wdata[7:0]`, and a queue read returns only the low byte.
- R7: While `cs_n` is 1, no beat is acknowledged and no register, queue or flag changes.
- R8: A transfer whose first beat has `last_n` = 0 is a single transfer. It is acknowledged in the same clock that `cs_n` is low, and `wait_n` has no effect on it.
- R9: A transfer whose first beat has `last_n` = 1 is a burst. Each beat is acknowledged after one clock when `wait_n` = 1 and after two clocks when `wait_n` = 0. The burst ends with the beat acknowledged while `last_n` = 0.
- R10: Host queue writes leave on the tx stream in order. A write to the full outbound queue (8 words) is dropped and sets the sticky `ovf_flag`.
- R11: Inbound words are read by the host in arrival order, and `rx_ready` is 0 while 8 words are held. A host queue read of an empty inbound queue returns 0 and sets the sticky `unf_flag`.
- R12: `beat_ack` is high for exactly one clock per beat, and only in a clock where `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_size | input | 2 | Host width: 00 = 8-bit, 01 = 16-bit, 10/11 = 32-bit |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write, 1 = read |
| word_addr | input | 5 | Register index (host address bits 6:2) |
| fifo_sel | input | 1 | 1 = queue window, 0 = register bank |
| lane_en_n | input | 4 | Active-low byte lane enables; bit 0 is address bit 0 in 8-bit width |
| last_n | input | 1 | Active low: marks the final beat |
| wait_n | input | 1 | Active low: stretches burst beats to two clocks |
| wdata | input | 32 | Host write data |
| beat_ack | output | 1 | Beat completes this clock |
| rd_valid | output | 1 | `rdata` carries new read data |
| rdata | output | 32 | Registered read data |
| ovf_flag | output | 1 | Sticky: a host queue write was dropped |
| unf_flag | output | 1 | Sticky: a host queue read found no data |
| tx_valid | output | 1 | Outbound stream valid |
| tx_ready | input | 1 | Outbound stream ready |
| tx_data | output | 32 | Outbound stream word |
| rx_valid | input | 1 | Inbound stream valid |
| rx_ready | output | 1 | Inbound stream ready |
| rx_data | input | 32 | Inbound stream word |

## Verification
The hardest situation to reach from the ports is a wait-stretched burst that crosses a queue boundary. In that case the outbound queue fills in the middle of the burst while the consumer holds `tx_ready` low, so a stretched beat is acknowledged and dropped at the same time. The stimulus gets there by first filling the outbound queue almost to capacity with the consumer stalled, then issuing a burst with `wait_n` low that has more beats than there are free slots. The bench holds the address and data of each beat until its behavioural model predicts the acknowledge. In the same way, it fills the inbound queue from the stream side until `rx_ready` drops, and then drains it with a burst of queue reads that runs one read past empty.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    BW8  = 2'b00,
    BW16 = 2'b01,
    BW32 = 2'b10
  } bus_width_t;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_BURST = 1'b1
  } beat_phase_t;
endpackage

// File: rtl/hbus_lane.sv
module hbus_lane
  import hbus_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 16
) (
  input  logic [1:0]      bus_size,
  input  logic [DW/8-1:0] lane_en_n,
  input  logic [DW-1:0]   wdata,
  input  logic [RW-1:0]   reg_q,
  input  logic [DW-1:0]   fifo_q,
  output logic [RW/8-1:0] reg_bmask,
  output logic [RW-1:0]   reg_wval,
  output logic [DW-1:0]   fifo_wval,
  output logic [DW-1:0]   reg_rval,
  output logic [DW-1:0]   fifo_rval
);
  localparam int NL = DW / 8;
  localparam int RL = RW / 8;

  logic narrow8, wide16, a0;
  logic [NL-1:0] lane_on;
  logic [NL-1:0] lane_keep;
  logic [7:0]    sel_byte;

  assign narrow8 = (bus_size == BW8);
  assign wide16  = (bus_size == BW16);
  assign a0      = lane_en_n[0];

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam bit LOW  = (i == 0);
    localparam bit HALF = (i < 2);
    assign lane_on[i]   = narrow8 ? LOW : (wide16 ? (HALF && !lane_en_n[i]) : !lane_en_n[i]);
    assign lane_keep[i] = narrow8 ? LOW : (wide16 ? HALF : 1'b1);
    assign fifo_wval[8*i +: 8] = lane_on[i]   ? wdata[8*i +: 8]  : 8'h00;
    assign fifo_rval[8*i +: 8] = lane_keep[i] ? fifo_q[8*i +: 8] : 8'h00;
  end

  for (genvar j = 0; j < RL; j++) begin : g_reg
    localparam bit IS_LO = (j == 0);
    localparam bit IS_HI = (j == 1);
    assign reg_bmask[j] = narrow8 ? ((IS_LO && !a0) || (IS_HI && a0)) : lane_on[j];
    assign reg_wval[8*j +: 8] = narrow8 ? wdata[7:0] : wdata[8*j +: 8];
  end

  assign sel_byte = a0 ? reg_q[15:8] : reg_q[7:0];

  always_comb begin
    reg_rval = '0;
    if (narrow8) reg_rval[7:0] = sel_byte;
    else         reg_rval[RW-1:0] = reg_q;
  end
endmodule

// File: rtl/hbus_pacer.sv
module hbus_pacer
  import hbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic last_n,
  input  logic wait_n,
  output logic fire,
  output logic in_burst
);
  beat_phase_t phase_q;
  logic        hold_q;
  logic        single, stall;

  assign single   = (phase_q == PH_IDLE) && !last_n;
  assign stall    = !cs_n && !single && !wait_n && !hold_q;
  assign fire     = !cs_n && !stall;
  assign in_burst = (phase_q == PH_BURST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      hold_q  <= 1'b0;
    end else begin
      if (fire) phase_q <= last_n ? PH_BURST : PH_IDLE;
      if (cs_n)       hold_q <= 1'b0;
      else if (stall) hold_q <= 1'b1;
      else if (fire)  hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
  parameter int N  = 32,
  parameter int RW = 16,
  parameter int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [RW/8-1:0] bmask,
  input  logic [RW-1:0]   wval,
  output logic [RW-1:0]   rval
);
  localparam int RL = RW / 8;

  logic [RW-1:0] regs [N];

  for (genvar e = 0; e < N; e++) begin : g_ent
    for (genvar b = 0; b < RL; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[e][8*b +: 8] <= 8'h00;
        else if (we && addr == AW'(e) && bmask[b])
          regs[e][8*b +: 8] <= wval[8*b +: 8];
      end
    end
  end

  assign rval = regs[addr];
endmodule

// File: rtl/hbus_fifo.sv
module hbus_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RW         = 16,
  parameter int REGS       = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int AW         = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      bus_size,
  input  logic            cs_n,
  input  logic            we_n,
  input  logic [AW-1:0]   word_addr,
  input  logic            fifo_sel,
  input  logic [DW/8-1:0] lane_en_n,
  input  logic            last_n,
  input  logic            wait_n,
  input  logic [DW-1:0]   wdata,
  output logic            beat_ack,
  output logic            rd_valid,
  output logic [DW-1:0]   rdata,
  output logic            ovf_flag,
  output logic            unf_flag,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [DW-1:0]   tx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [DW-1:0]   rx_data
);
  localparam int RL = RW / 8;

  logic            fire, in_burst;
  logic            host_wr, host_rd;
  logic            reg_we, tx_push, rx_pop;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [RW-1:0]   reg_q, reg_wval;
  logic [RL-1:0]   reg_bmask;
  logic [DW-1:0]   rx_head, fifo_wval, reg_rval, fifo_rval;

  hbus_pacer u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .last_n  (last_n),
    .wait_n  (wait_n),
    .fire    (fire),
    .in_burst(in_burst)
  );

  hbus_lane #(.DW(DW), .RW(RW)) u_lane (
    .bus_size (bus_size),
    .lane_en_n(lane_en_n),
    .wdata    (wdata),
    .reg_q    (reg_q),
    .fifo_q   (rx_head),
    .reg_bmask(reg_bmask),
    .reg_wval (reg_wval),
    .fifo_wval(fifo_wval),
    .reg_rval (reg_rval),
    .fifo_rval(fifo_rval)
  );

  assign beat_ack = fire;
  assign host_wr  = fire && !we_n;
  assign host_rd  = fire && we_n;
  assign reg_we   = host_wr && !fifo_sel;
  assign tx_push  = host_wr && fifo_sel;
  assign rx_pop   = host_rd && fifo_sel;

  hbus_regfile #(.N(REGS), .RW(RW), .AW(AW)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .addr (word_addr),
    .bmask(reg_bmask),
    .wval (reg_wval),
    .rval (reg_q)
  );

  hbus_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk  (clk),
    .rst_n(rst_n),
    .push (tx_push),
    .din  (fifo_wval),
    .pop  (tx_ready),
    .dout (tx_data),
    .full (tx_full),
    .empty(tx_empty)
  );

  hbus_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk  (clk),
    .rst_n(rst_n),
    .push (rx_valid),
    .din  (rx_data),
    .pop  (rx_pop),
    .dout (rx_head),
    .full (rx_full),
    .empty(rx_empty)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      rd_valid <= host_rd;
      if (host_rd) begin
        if (!fifo_sel)     rdata <= reg_rval;
        else if (rx_empty) rdata <= '0;
        else               rdata <= fifo_rval;
      end
      if (tx_push && tx_full)  ovf_flag <= 1'b1;
      if (rx_pop && rx_empty)  unf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_size,
  input logic          cs_n,
  input logic          we_n,
  input logic          last_n,
  input logic          wait_n,
  input logic          beat_ack,
  input logic          rd_valid,
  input logic [DW-1:0] rdata,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          in_burst
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_no_ack_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !beat_ack);

  assert_single_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !last_n && !in_burst) |-> beat_ack);

  assert_wait_stretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(beat_ack) && !cs_n && !wait_n && in_burst) |-> !beat_ack);

  assert_read_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (rd_valid == $past(beat_ack && we_n)));

  assert_half_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && bus_size == 2'b01) |-> (rdata[DW-1:16] == '0));

  assert_byte_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && bus_size == 2'b00) |-> (rdata[DW-1:8] == '0));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(ovf_flag)) |-> ovf_flag);

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(tx_valid && !tx_ready)) |-> (tx_valid && $stable(tx_data)));

  assert_unf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(unf_flag)) |-> unf_flag);
endmodule

bind hbus_slave hbus_slave_chk #(.DW(DW)) u_chk (.*);

// File: tb/hbus_slave_tb.sv
module hbus_slave_tb;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  b_size = 2'b10;
  logic        b_cs_n = 1'b1, b_we_n = 1'b1, b_fsel = 1'b0;
  logic [4:0]  b_addr = '0;
  logic [3:0]  b_be_n = 4'hF;
  logic        b_last_n = 1'b1, b_wait_n = 1'b1;
  logic [31:0] b_wdata = '0;
  logic        b_txr = 1'b0, b_rxv = 1'b0;
  logic [31:0] b_rxd = '0;

  logic        beat_ack, rd_valid, ovf_flag, unf_flag, tx_valid, rx_ready;
  logic [31:0] rdata, tx_data;

  hbus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_size(b_size), .cs_n(b_cs_n), .we_n(b_we_n),
    .word_addr(b_addr), .fifo_sel(b_fsel), .lane_en_n(b_be_n), .last_n(b_last_n),
    .wait_n(b_wait_n), .wdata(b_wdata), .beat_ack(beat_ack), .rd_valid(rd_valid),
    .rdata(rdata), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .tx_valid(tx_valid),
    .tx_ready(b_txr), .tx_data(tx_data), .rx_valid(b_rxv), .rx_ready(rx_ready),
    .rx_data(b_rxd)
  );

  int errors = 0, checks = 0;
  string cur = "R1";

  logic [15:0] mreg [32];
  logic [31:0] txq [$];
  logic [31:0] rxq [$];
  bit          m_burst = 0, m_hold = 0, m_rv = 0, m_ovf = 0, m_unf = 0, m_fired = 0;
  logic [31:0] m_rd = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] keep_fmt(input logic [1:0] sz, input logic [31:0] w);
    if (sz == 2'b00) return {24'b0, w[7:0]};
    if (sz == 2'b01) return {16'b0, w[15:0]};
    return w;
  endfunction

  function automatic logic [31:0] push_fmt(input logic [1:0] sz, input logic [3:0] be, input logic [31:0] w);
    logic [31:0] r = '0;
    if (sz == 2'b00) return {24'b0, w[7:0]};
    for (int i = 0; i < 4; i++)
      if (!be[i] && (sz != 2'b01 || i < 2)) r[8*i +: 8] = w[8*i +: 8];
    return r;
  endfunction

  function automatic bit model_fire();
    bit single = !m_burst && !b_last_n;
    bit stall  = !b_cs_n && !single && !b_wait_n && !m_hold;
    return !b_cs_n && !stall;
  endfunction

  task automatic step();
    bit f, txpop, rxpush, rxpop, wpush;
    int txn, rxn;
    logic [31:0] wword;
    #1;
    f = model_fire();
    chk(beat_ack === f, {cur, " ack R12"}, {31'b0, beat_ack}, {31'b0, f});
    chk(tx_valid === (txq.size() > 0), "R10 tx_valid", {31'b0, tx_valid}, {31'b0, txq.size() > 0});
    if (txq.size() > 0) chk(tx_data === txq[0], "R10 tx_data", tx_data, txq[0]);
    chk(rx_ready === (rxq.size() < DEPTH), "R11 rx_ready", {31'b0, rx_ready}, {31'b0, rxq.size() < DEPTH});
    @(posedge clk);
    txn = txq.size(); rxn = rxq.size();
    txpop = (txn > 0) && b_txr;
    rxpush = b_rxv && (rxn < DEPTH);
    rxpop = 0; wpush = 0; wword = '0; m_rv = 0;
    if (f) begin
      if (!b_we_n) begin
        if (b_fsel) begin
          if (txn < DEPTH) begin wpush = 1; wword = push_fmt(b_size, b_be_n, b_wdata); end
          else m_ovf = 1;
        end else if (b_size == 2'b00) begin
          if (b_be_n[0]) mreg[b_addr][15:8] = b_wdata[7:0];
          else           mreg[b_addr][7:0]  = b_wdata[7:0];
        end else begin
          if (!b_be_n[0]) mreg[b_addr][7:0]  = b_wdata[7:0];
          if (!b_be_n[1]) mreg[b_addr][15:8] = b_wdata[15:8];
        end
      end else begin
        m_rv = 1;
        if (b_fsel) begin
          if (rxn > 0) begin m_rd = keep_fmt(b_size, rxq[0]); rxpop = 1; end
          else begin m_rd = '0; m_unf = 1; end
        end else if (b_size == 2'b00)
          m_rd = {24'b0, b_be_n[0] ? mreg[b_addr][15:8] : mreg[b_addr][7:0]};
        else
          m_rd = {16'b0, mreg[b_addr]};
      end
    end
    if (txpop) void'(txq.pop_front());
    if (wpush) txq.push_back(wword);
    if (rxpop) void'(rxq.pop_front());
    if (rxpush) txq.size();
    if (rxpush) rxq.push_back(b_rxd);
    if (b_cs_n) m_hold = 0;
    else if (!f) m_hold = 1;
    else m_hold = 0;
    if (f) m_burst = b_last_n;
    m_fired = f;
    @(negedge clk);
    chk(rd_valid === m_rv, {cur, " rd_valid R3"}, {31'b0, rd_valid}, {31'b0, m_rv});
    if (m_rv) chk(rdata === m_rd, {cur, " rdata"}, rdata, m_rd);
    chk(ovf_flag === m_ovf, "R10 ovf", {31'b0, ovf_flag}, {31'b0, m_ovf});
    chk(unf_flag === m_unf, "R11 unf", {31'b0, unf_flag}, {31'b0, m_unf});
  endtask

  task automatic idle(input int n);
    b_cs_n = 1; b_last_n = 1;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic single(input bit we, input bit fs, input int a, input logic [3:0] be,
                        input logic [31:0] d, input bit wt);
    b_cs_n = 0; b_we_n = we; b_fsel = fs; b_addr = 5'(a); b_be_n = be;
    b_wdata = d; b_last_n = 0; b_wait_n = wt;
    step();
    idle(1);
  endtask

  task automatic burst(input int n, input bit we, input bit fs, input int a, input logic [3:0] be,
                       input logic [31:0] d, input bit wt);
    for (int k = 0; k < n; k++) begin
      b_cs_n = 0; b_we_n = we; b_fsel = fs; b_addr = 5'(a + k); b_be_n = be;
      b_wdata = d + 32'(k * 32'h01010101); b_wait_n = wt;
      b_last_n = (k == n - 1) ? 1'b0 : 1'b1;
      for (int t = 0; t < 4; t++) begin
        step();
        if (m_fired) break;
      end
    end
    idle(1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(rd_valid === 1'b0, "R1 rd_valid", {31'b0, rd_valid}, 32'd0);
    chk(rdata === 32'd0, "R1 rdata", rdata, 32'd0);
    chk(tx_valid === 1'b0 && rx_ready === 1'b1, "R1 streams", {30'b0, tx_valid, rx_ready}, 32'd1);
    cur = "R1"; single(1, 0, 5, 4'h0, 0, 1);

    // R2 R3 R4: 32-bit register access
    cur = "R2";
    single(0, 0, 3, 4'b0000, 32'hDEAD_BEEF, 1);
    single(0, 0, 31, 4'b1110, 32'h1111_2233, 1);
    single(0, 0, 3, 4'b0011, 32'h5566_7788, 1);
    single(0, 0, 3, 4'b1101, 32'h0000_4400, 1);
    cur = "R3"; single(1, 0, 3, 4'b0000, 0, 1);
    cur = "R4"; single(1, 0, 31, 4'b1111, 0, 1);
    single(1, 0, 30, 4'b0000, 0, 1);

    // R7: no access while deselected
    cur = "R7";
    b_cs_n = 1; b_we_n = 0; b_fsel = 0; b_addr = 3; b_be_n = 0; b_wdata = 32'hFFFF_FFFF; b_last_n = 0;
    step(); b_fsel = 1; step(); b_we_n = 1; step();
    single(1, 0, 3, 4'b0000, 0, 1);

    // R8: single transfer ignores wait
    cur = "R8";
    single(0, 0, 7, 4'b0000, 32'h0000_A5A5, 0);
    single(1, 0, 7, 4'b0000, 0, 0);

    // R10 R4: queue writes with random address, overflow, drain
    cur = "R10";
    b_txr = 0;
    for (int i = 0; i < 6; i++) single(0, 1, i * 5, 4'b0000, 32'hC000_0000 + 32'(i), 1);
    cur = "R9";
    burst(4, 0, 1, 9, 4'b0000, 32'h1234_0000, 0);
    cur = "R10";
    b_txr = 1; idle(10); b_txr = 0;

    // R11: empty read, fill from stream, burst drain past empty
    cur = "R11";
    single(1, 1, 2, 4'b0000, 0, 1);
    b_rxv = 1; b_rxd = 32'h7000_0000;
    for (int i = 0; i < 12; i++) begin
      step();
      if (b_rxv && rxq.size() > 0 && rxq[$] == b_rxd) b_rxd = b_rxd + 1;
    end
    b_rxv = 0;
    cur = "R9";
    burst(9, 1, 1, 0, 4'b0000, 0, 0);
    burst(3, 0, 0, 10, 4'b0000, 32'h0102_0304, 1);
    burst(3, 1, 0, 10, 4'b0000, 0, 1);

    // R5: 16-bit width
    cur = "R5";
    b_size = 2'b01;
    single(0, 0, 12, 4'b0000, 32'hABCD_1357, 1);
    single(1, 0, 12, 4'b0000, 0, 1);
    single(0, 1, 0, 4'b0000, 32'hFEDC_BA98, 1);
    b_rxv = 1; b_rxd = 32'h8765_4321; step(); b_rxv = 0;
    single(1, 1, 0, 4'b0000, 0, 1);

    // R6: 8-bit width with lane 0 as address bit 0
    cur = "R6";
    b_size = 2'b00;
    single(0, 0, 20, 4'b1110, 32'h0000_0042, 1);
    single(0, 0, 20, 4'b1111, 32'h0000_0099, 1);
    single(1, 0, 20, 4'b1110, 0, 1);
    single(1, 0, 20, 4'b1111, 0, 1);
    single(0, 1, 0, 4'b1111, 32'h1234_5677, 1);
    b_rxv = 1; b_rxd = 32'hAABB_CCDD; step(); b_rxv = 0;
    single(1, 1, 0, 4'b1111, 0, 1);
    b_size = 2'b10;
    cur = "R3"; single(1, 0, 20, 4'b0000, 0, 1);
    b_txr = 1; idle(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule